// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter Bank

This block sits behind a CAN frame decoder and decides, for every received frame, whether its identifier bytes pass a bank of programmable acceptance filters. The filter storage is a shared set of eight code bytes and eight mask bytes. A 2-bit layout field divides it into two 32-bit filters, four 16-bit filters or eight 8-bit filters. A fourth setting shuts the bank so that nothing is accepted. A mask bit of one makes the matching identifier bit a don't-care.

An accepted frame is queued, with the number of the filter that matched it, in a four-entry receive queue. The head of that queue is the foreground slot the host reads. The reported hit code and identifier always belong to that foreground message, not to the newest arrival. The host releases the foreground slot with a one-cycle acknowledge pulse, and the next queued message moves forward. A frame accepted while the queue is full is discarded and raises a sticky overrun flag.

The queue is controlled by a three-state machine. `Q_EMPTY` has no message in the foreground. `Q_PART` holds between one and DEPTH-1 messages. `Q_FULL` holds DEPTH messages. The transitions are:
- ARRIVE_FIRST (`Q_EMPTY` to `Q_PART`): an accepted frame arrives.
- DRAIN_LAST (`Q_PART` to `Q_EMPTY`): the last message is acknowledged.
- FILL_LAST (`Q_PART` to `Q_FULL`): the occupancy reaches DEPTH.
- FREE_ONE (`Q_FULL` to `Q_PART`): an acknowledge arrives with no accepted frame in the same cycle.

Filter registers are written through a byte port:
- Addresses 0 to 7 hold the code bytes.
- Addresses 8 to 15 hold the mask bytes.
- Address 16 holds the layout field in bits 1:0.

Top module: `can_accept_bank`

## Requirements
- R1: After reset the layout field is 00, all code and mask bytes are zero, the queue is empty (`fg_valid`=0, `fifo_count`=0), `hit_idx` reads 000 and `overrun` is 0.
- R2: Layout 00 gives two 32-bit filters. Filter f uses code/mask bytes 4f..4f+3, and byte 4f+b is compared with identifier byte b, where byte b is `frame_id[8b+7:8b]`. A filter matches when every unmasked bit equals its code bit.
- R3: Layout 01 gives four 16-bit filters. Filter f uses bytes 2f and 2f+1, compared with identifier bytes 0 and 1. Identifier bytes 2 and 3 are ignored.
- R4: Layout 10 gives eight 8-bit filters. Filter f uses byte f, compared with identifier byte 0 only.
- R5: Layout 11 accepts no frame. The queue contents, `fifo_count` and the foreground outputs do not change except through an acknowledge.
- R6: When several filters match a frame, the lowest-numbered one is reported as a 3-bit binary index (000 = filter 0 to 111 = filter 7), and the frame is queued once.
- R7: `hit_idx` and `fg_id` describe the foreground message. They change only when a message moves into the foreground, which happens on arrival into an empty queue or on an acknowledge. When the queue drains they hold their last value.
- R8: The queue holds 4 messages in arrival order. An acknowledge removes the head, and an acknowledge on an empty queue has no effect.
- R9: An accepted frame that finds the queue full, with no acknowledge in the same cycle, is dropped and sets `overrun`. `overrun` stays set until an `ovr_clr` pulse.
- R10: An acknowledge and an accepted frame in the same cycle on a full queue both take effect, with no drop and no overrun. A new overrun and `ovr_clr` in the same cycle leave `overrun` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Filter register write strobe |
| cfg_addr | input | 5 | Filter register address (0-7 code, 8-15 mask, 16 layout) |
| cfg_wdata | input | 8 | Filter register write data |
| frame_valid | input | 1 | One-cycle strobe: identifier of a received frame is present |
| frame_id | input | 32 | Identifier bytes, byte b in bits 8b+7:8b |
| host_ack | input | 1 | Host releases the foreground message |
| ovr_clr | input | 1 | Clears the overrun flag |
| fg_valid | output | 1 | A message is in the foreground slot |
| fg_id | output | 32 | Identifier bytes of the foreground message |
| hit_idx | output | 3 | Filter index that accepted the foreground message |
| fifo_count | output | 3 | Number of queued messages |
| overrun | output | 1 | Sticky flag: an accepted frame was dropped |

## Verification
Two actions can land on the same clock edge: the host releasing the foreground slot, and the filter accepting a new frame while the queue is full. The bench fills the queue, then raises `host_ack` and `frame_valid` in one cycle. It expects the count to stay at four, no overrun, the next hit code in the foreground, and the new frame to appear last when the queue drains. It also sets an overrun in the same cycle as `ovr_clr` and expects the flag to stay set.

// File: rtl/can_acc_pkg.sv
package can_acc_pkg;
    typedef enum logic [1:0] {
        MODE_W32  = 2'b00,
        MODE_W16  = 2'b01,
        MODE_W8   = 2'b10,
        MODE_SHUT = 2'b11
    } acc_mode_e;

    localparam int unsigned ID_BYTES   = 4;
    localparam int unsigned BANK_BYTES = 2 * ID_BYTES;
    localparam int unsigned HIT_W      = $clog2(BANK_BYTES);
    localparam int unsigned N_LAYOUTS  = 3;
endpackage

// File: rtl/acc_filter_regs.sv
module acc_filter_regs
    import can_acc_pkg::*;
#(
    parameter int unsigned NB = BANK_BYTES,
    parameter int unsigned AW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [AW-1:0]   addr,
    input  logic [7:0]      wdata,
    output logic [NB*8-1:0] code,
    output logic [NB*8-1:0] mask,
    output acc_mode_e       mode
);
    localparam int unsigned MASK_BASE = NB;
    localparam int unsigned MODE_ADDR = 2 * NB;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code <= '0;
            mask <= '0;
            mode <= MODE_W32;
        end else if (we) begin
            for (int k = 0; k < int'(NB); k++) begin
                if (int'(addr) == k)
                    code[k*8 +: 8] <= wdata;
                if (int'(addr) == k + int'(MASK_BASE))
                    mask[k*8 +: 8] <= wdata;
            end
            if (int'(addr) == int'(MODE_ADDR))
                mode <= acc_mode_e'(wdata[1:0]);
        end
    end
endmodule

// File: rtl/acc_match_unit.sv
module acc_match_unit
    import can_acc_pkg::*;
#(
    parameter int unsigned NB = BANK_BYTES,
    parameter int unsigned IB = ID_BYTES,
    parameter int unsigned HW = HIT_W
) (
    input  logic [NB*8-1:0] code,
    input  logic [NB*8-1:0] mask,
    input  acc_mode_e       mode,
    input  logic [IB*8-1:0] id,
    output logic            any_hit,
    output logic [HW-1:0]   hit_num
);
    logic [NB-1:0] layout_hits [N_LAYOUTS];
    logic [NB-1:0] sel_hits;

    for (genvar m = 0; m < int'(N_LAYOUTS); m++) begin : g_layout
        localparam int BPF = int'(IB) >> m;
        localparam int NF  = int'(NB) / BPF;
        logic [NB-1:0] fhit;
        for (genvar f = 0; f < int'(NB); f++) begin : g_filt
            if (f < NF) begin : g_used
                logic [BPF-1:0] byte_ok;
                for (genvar b = 0; b < BPF; b++) begin : g_byte
                    localparam int K = f * BPF + b;
                    assign byte_ok[b] =
                        &(~(id[b*8 +: 8] ^ code[K*8 +: 8]) | mask[K*8 +: 8]);
                end
                assign fhit[f] = &byte_ok;
            end else begin : g_none
                assign fhit[f] = 1'b0;
            end
        end
        assign layout_hits[m] = fhit;
    end

    always_comb begin
        unique case (mode)
            MODE_W32:  sel_hits = layout_hits[0];
            MODE_W16:  sel_hits = layout_hits[1];
            MODE_W8:   sel_hits = layout_hits[2];
            MODE_SHUT: sel_hits = '0;
            default:   sel_hits = '0;
        endcase
    end

    always_comb begin
        hit_num = '0;
        for (int k = int'(NB) - 1; k >= 0; k--) begin
            if (sel_hits[k])
                hit_num = HW'(k);
        end
        any_hit = |sel_hits;
    end
endmodule

// File: rtl/acc_rx_queue.sv
module acc_rx_queue #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned DW    = 35,
    localparam int unsigned PW   = $clog2(DEPTH),
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    input  logic          ovr_clr,
    output logic          fg_valid,
    output logic [DW-1:0] fg_data,
    output logic [CW-1:0] count,
    output logic          overrun
);
    typedef enum logic [1:0] {Q_EMPTY, Q_PART, Q_FULL} q_state_e;

    q_state_e      state, state_n;
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr, rd_n;
    logic [CW-1:0] count_n;
    logic          pop_ok, push_ok, drop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (int'(p) == int'(DEPTH) - 1) ? '0 : p + 1'b1;
    endfunction

    assign pop_ok  = pop && (state != Q_EMPTY);
    assign push_ok = push && ((state != Q_FULL) || pop_ok);
    assign drop    = push && !push_ok;
    assign rd_n    = pop_ok ? bump(rd_ptr) : rd_ptr;
    assign count_n = count + CW'(push_ok) - CW'(pop_ok);

    // next-state logic: ARRIVE_FIRST, DRAIN_LAST, FILL_LAST, FREE_ONE
    always_comb begin
        state_n = state;
        unique case (state)
            Q_EMPTY: if (push_ok) state_n = Q_PART;
            Q_PART: begin
                if (count_n == '0)
                    state_n = Q_EMPTY;
                else if (int'(count_n) == int'(DEPTH))
                    state_n = Q_FULL;
            end
            Q_FULL: if (pop_ok && !push_ok) state_n = Q_PART;
            default: state_n = Q_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= Q_EMPTY;
        else        state <= state_n;
    end

    // storage and pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
            for (int k = 0; k < int'(DEPTH); k++) mem[k] <= '0;
        end else begin
            if (push_ok) begin
                mem[wr_ptr] <= push_data;
                wr_ptr      <= bump(wr_ptr);
            end
            rd_ptr <= rd_n;
            count  <= count_n;
        end
    end

    // outputs: foreground slot and overrun flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fg_data  <= '0;
            fg_valid <= 1'b0;
            overrun  <= 1'b0;
        end else begin
            fg_valid <= (state_n != Q_EMPTY);
            if ((count_n != '0) && (pop_ok || state == Q_EMPTY))
                fg_data <= (push_ok && wr_ptr == rd_n) ? push_data : mem[rd_n];
            if (drop)
                overrun <= 1'b1;
            else if (ovr_clr)
                overrun <= 1'b0;
        end
    end
endmodule

// File: rtl/can_accept_bank.sv
module can_accept_bank
    import can_acc_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned AW   = $clog2(2 * BANK_BYTES + 1),
    localparam int unsigned IW   = ID_BYTES * 8,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [7:0]    cfg_wdata,
    input  logic          frame_valid,
    input  logic [IW-1:0] frame_id,
    input  logic          host_ack,
    input  logic          ovr_clr,
    output logic          fg_valid,
    output logic [IW-1:0] fg_id,
    output logic [HIT_W-1:0] hit_idx,
    output logic [CW-1:0] fifo_count,
    output logic          overrun
);
    localparam int unsigned DW = IW + HIT_W;

    logic [BANK_BYTES*8-1:0] code_q, mask_q;
    acc_mode_e               mode_q;
    logic                    any_hit;
    logic [HIT_W-1:0]        hit_num;
    logic [DW-1:0]           fg_data;

    acc_filter_regs #(.NB(BANK_BYTES), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .code(code_q), .mask(mask_q), .mode(mode_q)
    );

    acc_match_unit #(.NB(BANK_BYTES), .IB(ID_BYTES), .HW(HIT_W)) u_match (
        .code(code_q), .mask(mask_q), .mode(mode_q), .id(frame_id),
        .any_hit(any_hit), .hit_num(hit_num)
    );

    acc_rx_queue #(.DEPTH(DEPTH), .DW(DW)) u_queue (
        .clk(clk), .rst_n(rst_n),
        .push(frame_valid && any_hit), .push_data({hit_num, frame_id}),
        .pop(host_ack), .ovr_clr(ovr_clr),
        .fg_valid(fg_valid), .fg_data(fg_data),
        .count(fifo_count), .overrun(overrun)
    );

    assign hit_idx = fg_data[DW-1 -: HIT_W];
    assign fg_id   = fg_data[IW-1:0];
endmodule

// File: rtl/can_accept_bank_chk.sv
module can_accept_bank_chk #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned CW    = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          frame_valid,
    input logic          host_ack,
    input logic          ovr_clr,
    input logic [1:0]    mode,
    input logic          fg_valid,
    input logic [2:0]    hit_idx,
    input logic [CW-1:0] fifo_count,
    input logic          overrun
);
    assert_depth_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fifo_count) <= int'(DEPTH));

    assert_fg_matches_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fg_valid == (fifo_count != '0));

    assert_last_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ack && fifo_count == CW'(1) && !frame_valid) |=> !fg_valid);

    assert_closed_no_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11 && !host_ack) |=> fifo_count <= $past(fifo_count));

    assert_hit_follows_fg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(hit_idx) |-> $past(host_ack || (frame_valid && fifo_count == '0)));

    assert_ovr_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(frame_valid && int'(fifo_count) == int'(DEPTH) && !host_ack));

    assert_ovr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_clr) |=> overrun);
endmodule

bind can_accept_bank can_accept_bank_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .host_ack(host_ack),
    .ovr_clr(ovr_clr), .mode(mode_q), .fg_valid(fg_valid), .hit_idx(hit_idx),
    .fifo_count(fifo_count), .overrun(overrun)
);

// File: tb/can_accept_bank_tb_top.sv
module can_accept_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        frame_valid = 1'b0;
    logic [31:0] frame_id = '0;
    logic        host_ack = 1'b0;
    logic        ovr_clr = 1'b0;
    logic        fg_valid;
    logic [31:0] fg_id;
    logic [2:0]  hit_idx;
    logic [2:0]  fifo_count;
    logic        overrun;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    can_accept_bank dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .frame_valid(frame_valid), .frame_id(frame_id),
        .host_ack(host_ack), .ovr_clr(ovr_clr), .fg_valid(fg_valid),
        .fg_id(fg_id), .hit_idx(hit_idx), .fifo_count(fifo_count),
        .overrun(overrun)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic load_bank(input logic [63:0] codes, input logic [63:0] masks,
                             input logic [1:0] md);
        for (int k = 0; k < 8; k++) wr(k, codes[k*8 +: 8]);
        for (int k = 0; k < 8; k++) wr(k + 8, masks[k*8 +: 8]);
        wr(16, {6'd0, md});
    endtask

    task automatic send(input logic [31:0] id);
        @(negedge clk);
        frame_valid = 1'b1; frame_id = id;
        @(negedge clk);
        frame_valid = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk);
        host_ack = 1'b1;
        @(negedge clk);
        host_ack = 1'b0;
    endtask

    task automatic clear_all();
        for (int k = 0; k < 6; k++) ack();
        @(negedge clk); ovr_clr = 1'b1;
        @(negedge clk); ovr_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "fg_valid", 32'(fg_valid), 0);
        chk("R1", "fifo_count", 32'(fifo_count), 0);
        chk("R1", "hit_idx", 32'(hit_idx), 0);
        chk("R1", "overrun", 32'(overrun), 0);
        send(32'h0000_0000);   // zero code, zero mask, layout 00 -> filter 0
        chk("R1", "zero id accepted", 32'(fifo_count), 1);
        chk("R1", "hit after default", 32'(hit_idx), 0);
        send(32'h0000_0001);
        chk("R1", "nonzero id rejected", 32'(fifo_count), 1);
        clear_all();
    endtask

    task automatic t_w32();
        load_bank(64'hDDCC_BBAA_4433_2211, 64'hFF00_0000_0000_0000, 2'b00);
        send(32'h4433_2211);
        chk("R2", "filter0 hit", 32'(hit_idx), 0);
        chk("R2", "fg_id", fg_id, 32'h4433_2211);
        send(32'h55CC_BBAA);   // byte 3 masked in filter 1
        chk("R2", "count after masked match", 32'(fifo_count), 2);
        chk("R7", "hit stays with foreground", 32'(hit_idx), 0);
        send(32'h4433_2212);
        chk("R2", "mismatch rejected", 32'(fifo_count), 2);
        ack();
        chk("R7", "hit after shift", 32'(hit_idx), 1);
        chk("R7", "fg_id after shift", fg_id, 32'h55CC_BBAA);
        clear_all();
    endtask

    task automatic t_w16();
        load_bank(64'h6050_4030_2010_0201, 64'h00FF_0000_0000_0000, 2'b01);
        send(32'hFFFF_2010);   // upper bytes ignored
        chk("R3", "filter1 hit", 32'(hit_idx), 1);
        send(32'h0000_6077);   // filter 3, first byte masked
        chk("R3", "count", 32'(fifo_count), 2);
        ack();
        chk("R3", "filter3 hit", 32'(hit_idx), 3);
        send(32'h0000_0102);
        chk("R3", "swapped bytes rejected", 32'(fifo_count), 1);
        clear_all();
    endtask

    task automatic t_w8();
        load_bank(64'h8786_8584_8382_8180, 64'h0, 2'b10);
        send(32'h1234_5685);
        chk("R4", "filter5 hit", 32'(hit_idx), 5);
        ack();
        send(32'hA5A5_A587);
        chk("R4", "filter7 hit", 32'(hit_idx), 7);
        clear_all();
    endtask

    task automatic t_prio();
        load_bank(64'hF75A_F5F4_F35A_F1F0, 64'h0, 2'b10);
        send(32'h0000_005A);
        chk("R6", "lowest of 2 and 6", 32'(hit_idx), 2);
        chk("R6", "queued once", 32'(fifo_count), 1);
        clear_all();
        wr(9, 8'hFF);          // filter 1 fully masked
        send(32'h0000_005A);
        chk("R6", "masked filter1 wins", 32'(hit_idx), 1);
        chk("R6", "queued once again", 32'(fifo_count), 1);
        // layout 11 with one message held
        wr(16, 8'h03);
        send(32'h0000_005A);
        chk("R5", "closed: count kept", 32'(fifo_count), 1);
        chk("R5", "closed: hit kept", 32'(hit_idx), 1);
        ack();
        send(32'h0000_00F0);
        chk("R5", "closed: empty stays empty", 32'(fg_valid), 0);
        chk("R7", "hit held after drain", 32'(hit_idx), 1);
        clear_all();
    endtask

    task automatic t_fifo();
        load_bank(64'h8786_8584_8382_8180, 64'h0, 2'b10);
        for (int k = 1; k <= 4; k++) send(32'h80 + 32'(k));
        chk("R8", "full count", 32'(fifo_count), 4);
        send(32'h85);
        chk("R9", "drop keeps count", 32'(fifo_count), 4);
        chk("R9", "overrun set", 32'(overrun), 1);
        chk("R8", "head unchanged", 32'(hit_idx), 1);
        for (int k = 2; k <= 4; k++) begin
            ack();
            chk("R8", "order", 32'(hit_idx), 32'(k));
        end
        ack();
        chk("R8", "drained", 32'(fg_valid), 0);
        ack();
        chk("R8", "ack on empty ignored", 32'(fifo_count), 0);
        chk("R9", "overrun sticky", 32'(overrun), 1);
        @(negedge clk); ovr_clr = 1'b1;
        @(negedge clk); ovr_clr = 1'b0;
        chk("R9", "overrun cleared", 32'(overrun), 0);
    endtask

    task automatic t_same_cycle();
        for (int k = 0; k <= 3; k++) send(32'h80 + 32'(k));
        @(negedge clk);
        frame_valid = 1'b1; frame_id = 32'h85; host_ack = 1'b1;
        @(negedge clk);
        frame_valid = 1'b0; host_ack = 1'b0;
        chk("R10", "swap keeps full", 32'(fifo_count), 4);
        chk("R10", "no overrun on swap", 32'(overrun), 0);
        chk("R10", "head advanced", 32'(hit_idx), 1);
        @(negedge clk);
        frame_valid = 1'b1; frame_id = 32'h86; ovr_clr = 1'b1;
        @(negedge clk);
        frame_valid = 1'b0; ovr_clr = 1'b0;
        chk("R10", "set beats clear", 32'(overrun), 1);
        ack(); chk("R10", "drain 1", 32'(hit_idx), 2);
        ack(); chk("R10", "drain 2", 32'(hit_idx), 3);
        ack(); chk("R10", "swapped frame last", 32'(hit_idx), 5);
        ack(); chk("R10", "empty at end", 32'(fifo_count), 0);
    endtask

    initial begin
        #(20 * 150000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_w32();
        t_w16();
        t_w8();
        t_prio();
        t_fifo();
        t_same_cycle();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule